// File: doc/BRIEF.md
# Absolute Encoder Serial Transaction Sequencer

This block runs a single request/response exchange with an absolute rotary position encoder over a half-duplex RS485 pair. The host supplies a 4-bit data ID, an EEPROM address byte and an EEPROM write byte, then pulses a start input. From the data ID the block works out how many request bytes to send and how many reply bytes to expect. It raises the line-driver enable and sends the request through its own 8N1 serial transmitter.

The receiver input is never gated, so each request byte comes straight back on the receive line. The sequencer waits for each echo before it sends the next byte, and it drops the echoes. After the last request byte has fully left the transmitter, the sequencer releases the driver. It then stores the encoder's reply bytes in a small buffer that the host reads through a registered read port.

A missing byte, a bad stop bit or an unsupported data ID ends the exchange with the fail flag set. The meaning of the reply bytes is left to the host.

Top module: `enc_txn_seq`

## Requirements
- R1: After reset, cmd_busy, cmd_fail and line_de are 0, line_txd is 1 and reply_cnt is 0.
- R2: Every character on line_txd is ten bit times long. It is one start bit (0), eight data bits sent LSB first, and one stop bit (1), with no parity. One bit time is OSR × max(1, CLK_HZ/(BAUD_HZ·OSR)) clock cycles.
- R3: The first request byte is the control byte {^id, id[3:0], 3'b010}. ID D (EEPROM read) then sends addr and ctrl^addr. ID 6 (EEPROM write) then sends addr, wdata and ctrl^addr^wdata. Every other supported ID sends only the control byte.
- R4: line_de is 1 in every cycle in which line_txd is 0. line_de is 0 in every cycle in which cmd_busy is 0. line_de falls only after the stop bit of the final request byte has ended.
- R5: Each request byte after the first is started only after the echo of the previous byte has been received. Echoed bytes never enter the reply buffer or reply_cnt.
- R6: The expected reply length is 6 bytes for IDs 0, 1, 7, 8 and C, 4 bytes for IDs 2, 6 and D, and 11 bytes for ID 3. On success cmd_fail is 0 and reply_cnt equals that length. Reply byte k can be read at rd_data one cycle after rd_addr = k.
- R7: A start pulse in idle with a supported ID makes cmd_busy 1 on the next cycle and clears cmd_fail and reply_cnt. cmd_busy returns to 0 when the exchange ends, and cmd_fail is valid and held from then until the next accepted start.
- R8: A start pulse in idle with an ID outside {0,1,2,3,6,7,8,C,D} leaves cmd_busy at 0, sets cmd_fail on the next cycle, clears reply_cnt and puts nothing on the line.
- R9: A start pulse while cmd_busy is 1 is ignored. The running exchange keeps its ID, its request bytes and its reply length.
- R10: If no start bit arrives within TIMEOUT_BITS bit times while an echo or a reply byte is awaited, the exchange ends with cmd_fail = 1. reply_cnt then holds the number of reply bytes received so far.
- R11: A received character whose stop bit is sampled at 0 ends the exchange with cmd_fail = 1. That character is not counted in reply_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_id | input | 4 | Data ID of the requested transaction |
| cmd_addr | input | 8 | EEPROM address byte |
| cmd_wdata | input | 8 | EEPROM write data byte |
| cmd_start | input | 1 | One-cycle start request |
| cmd_busy | output | 1 | High while an exchange is running |
| cmd_fail | output | 1 | Outcome of the last exchange, valid while not busy |
| reply_cnt | output | AW+1 | Reply bytes captured in the last exchange |
| rd_addr | input | AW | Reply buffer read index |
| rd_data | output | 8 | Reply byte, one cycle after rd_addr |
| line_txd | output | 1 | Serial data to the RS485 driver |
| line_de | output | 1 | RS485 driver enable |
| line_rxd | input | 1 | Serial data from the RS485 receiver |

## Verification
The bench builds the block with BAUD_HZ = 12.5 MHz against the 200 MHz clock, so one bit time is exactly 16 cycles and the tick divider reduces to a constant tick. This makes bit-exact sampling of each request character practical, and it lets all eleven transactions and their replies fit in a short run. TIMEOUT_BITS is set to 24, so a reply that stops early is aborted a few hundred cycles after the last byte. This brings the timeout path into reach alongside the framing-error path, the unsupported-ID path and the start-while-busy path.

// File: rtl/enc_seq_pkg.sv
package enc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_ECHO,
    ST_FLUSH,
    ST_REPLY
  } seq_state_t;

  // Data IDs that the encoder understands
  function automatic logic id_ok(input logic [3:0] id);
    case (id)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'hC, 4'hD: id_ok = 1'b1;
      default:                                               id_ok = 1'b0;
    endcase
  endfunction

  // Number of request bytes for an ID
  function automatic logic [2:0] req_len(input logic [3:0] id);
    case (id)
      4'h6:    req_len = 3'd4;
      4'hD:    req_len = 3'd3;
      default: req_len = 3'd1;
    endcase
  endfunction

  // Number of reply bytes for an ID
  function automatic logic [3:0] rsp_len(input logic [3:0] id);
    case (id)
      4'h2, 4'h6, 4'hD: rsp_len = 4'd4;
      4'h3:             rsp_len = 4'd11;
      default:          rsp_len = 4'd6;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic [3:0] id);
    ctrl_byte = {^id, id, 3'b010};
  endfunction

  // Request byte at position idx
  function automatic logic [7:0] req_byte(input logic [3:0] id, input logic [7:0] addr,
                                          input logic [7:0] wdata, input logic [1:0] idx);
    logic [7:0] c;
    c = ctrl_byte(id);
    case (idx)
      2'd0:    req_byte = c;
      2'd1:    req_byte = addr;
      2'd2:    req_byte = (id == 4'h6) ? wdata : (c ^ addr);
      default: req_byte = c ^ addr ^ wdata;
    endcase
  endfunction

endpackage

// File: rtl/enc_uart_tx.sv
module enc_uart_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] din,
  output logic       txd,
  output logic       idle
);
  localparam int OW = $clog2(OSR);

  logic [9:0]    sh;
  logic [3:0]    bitn;
  logic [OW-1:0] tc;
  logic          act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      bitn <= '0;
      tc   <= '0;
      act  <= 1'b0;
    end else if (!act) begin
      if (go) begin
        sh   <= {1'b1, din, 1'b0};
        bitn <= '0;
        tc   <= '0;
        act  <= 1'b1;
      end
    end else if (tick) begin
      if (tc == OW'(OSR - 1)) begin
        tc <= '0;
        if (bitn == 4'd9) begin
          act <= 1'b0;
          sh  <= '1;
        end else begin
          sh   <= {1'b1, sh[9:1]};
          bitn <= bitn + 4'd1;
        end
      end else begin
        tc <= tc + OW'(1);
      end
    end
  end

  assign txd  = sh[0];
  assign idle = !act;

endmodule

// File: rtl/enc_uart_rx.sv
module enc_uart_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  output logic       valid,
  output logic       ferr,
  output logic [7:0] dout,
  output logic       busy
);
  localparam int OW = $clog2(OSR);

  logic [1:0]    sy;
  logic          rxs;
  logic          act;
  logic [OW-1:0] tc;
  logic [3:0]    bitn;
  logic [7:0]    sh;

  assign rxs  = sy[1];
  assign busy = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy    <= 2'b11;
      act   <= 1'b0;
      tc    <= '0;
      bitn  <= '0;
      sh    <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
      dout  <= '0;
    end else begin
      sy    <= {sy[0], rxd};
      valid <= 1'b0;
      if (!act) begin
        if (!rxs) begin
          act  <= 1'b1;
          tc   <= '0;
          bitn <= '0;
        end
      end else if (tick) begin
        if (bitn == 4'd0) begin
          if (tc == OW'(OSR / 2 - 1)) begin
            if (rxs) act <= 1'b0;        // glitch, not a start bit
            else begin
              tc   <= '0;
              bitn <= 4'd1;
            end
          end else begin
            tc <= tc + OW'(1);
          end
        end else if (tc == OW'(OSR - 1)) begin
          tc <= '0;
          if (bitn == 4'd9) begin
            valid <= 1'b1;
            ferr  <= !rxs;
            dout  <= sh;
            act   <= 1'b0;
          end else begin
            sh   <= {rxs, sh[7:1]};
            bitn <= bitn + 4'd1;
          end
        end else begin
          tc <= tc + OW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/enc_reply_ram.sv
module enc_reply_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/enc_txn_seq.sv
module enc_txn_seq
  import enc_seq_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int BAUD_HZ      = 2_500_000,
  parameter int OSR          = 16,
  parameter int TIMEOUT_BITS = 64,
  parameter int REPLY_DEPTH  = 16,
  localparam int AW          = $clog2(REPLY_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cmd_id,
  input  logic [7:0]    cmd_addr,
  input  logic [7:0]    cmd_wdata,
  input  logic          cmd_start,
  output logic          cmd_busy,
  output logic          cmd_fail,
  output logic [AW:0]   reply_cnt,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          line_txd,
  output logic          line_de,
  input  logic          line_rxd
);
  localparam int DIV_RAW  = CLK_HZ / (BAUD_HZ * OSR);
  localparam int DIV      = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int DW       = $clog2(DIV + 1);
  localparam int TO_TICKS = TIMEOUT_BITS * OSR;
  localparam int TOW      = $clog2(TO_TICKS + 1);

  // Oversampling tick
  logic tick;
  generate
    if (DIV == 1) begin : g_tick_const
      assign tick = 1'b1;
    end else begin : g_tick_div
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (rst || dcnt == DW'(DIV - 1)) dcnt <= '0;
        else                            dcnt <= dcnt + DW'(1);
      end
      assign tick = (dcnt == DW'(DIV - 1));
    end
  endgenerate

  seq_state_t     state;
  logic [3:0]     id_q;
  logic [7:0]     addr_q, wdata_q;
  logic [1:0]     req_idx;
  logic [2:0]     req_n;
  logic [AW:0]    rsp_n;
  logic           tx_go;
  logic [7:0]     tx_byte;
  logic           tx_idle;
  logic           rx_valid, rx_ferr, rx_busy;
  logic [7:0]     rx_byte;
  logic [TOW-1:0] to_cnt;
  logic           waiting, to_hit, ram_we;

  enc_uart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .go(tx_go), .din(tx_byte),
    .txd(line_txd), .idle(tx_idle)
  );

  enc_uart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(line_rxd),
    .valid(rx_valid), .ferr(rx_ferr), .dout(rx_byte), .busy(rx_busy)
  );

  assign ram_we = (state == ST_REPLY) && rx_valid && !rx_ferr;

  enc_reply_ram #(.W(8), .DEPTH(REPLY_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(reply_cnt[AW-1:0]), .wdata(rx_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // Silence timer: counts ticks with no character in progress
  assign waiting = (state == ST_ECHO) || (state == ST_REPLY);
  always_ff @(posedge clk) begin
    if (rst || !waiting || rx_busy || rx_valid) to_cnt <= '0;
    else if (tick)                               to_cnt <= to_cnt + TOW'(1);
  end
  assign to_hit = waiting && tick && !rx_busy && (to_cnt == TOW'(TO_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      id_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      req_idx   <= '0;
      req_n     <= '0;
      rsp_n     <= '0;
      tx_go     <= 1'b0;
      tx_byte   <= '0;
      cmd_busy  <= 1'b0;
      cmd_fail  <= 1'b0;
      reply_cnt <= '0;
      line_de   <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            reply_cnt <= '0;
            if (id_ok(cmd_id)) begin
              id_q     <= cmd_id;
              addr_q   <= cmd_addr;
              wdata_q  <= cmd_wdata;
              req_idx  <= '0;
              req_n    <= req_len(cmd_id);
              rsp_n    <= (AW+1)'(rsp_len(cmd_id));
              cmd_busy <= 1'b1;
              cmd_fail <= 1'b0;
              line_de  <= 1'b1;
              state    <= ST_SEND;
            end else begin
              cmd_fail <= 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (tx_idle) begin
            tx_go   <= 1'b1;
            tx_byte <= req_byte(id_q, addr_q, wdata_q, req_idx);
            state   <= ST_ECHO;
          end
        end
        ST_ECHO: begin
          if (rx_valid && rx_ferr) begin
            cmd_fail <= 1'b1;
            cmd_busy <= 1'b0;
            line_de  <= 1'b0;
            state    <= ST_IDLE;
          end else if (rx_valid) begin
            req_idx <= req_idx + 2'd1;
            if ((3'(req_idx) + 3'd1) == req_n) state <= ST_FLUSH;
            else                               state <= ST_SEND;
          end else if (to_hit) begin
            cmd_fail <= 1'b1;
            cmd_busy <= 1'b0;
            line_de  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (tx_idle) begin
            line_de <= 1'b0;
            state   <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (rx_valid && rx_ferr) begin
            cmd_fail <= 1'b1;
            cmd_busy <= 1'b0;
            state    <= ST_IDLE;
          end else if (rx_valid) begin
            reply_cnt <= reply_cnt + (AW+1)'(1);
            if (reply_cnt + (AW+1)'(1) == rsp_n) begin
              cmd_busy <= 1'b0;
              state    <= ST_IDLE;
            end
          end else if (to_hit) begin
            cmd_fail <= 1'b1;
            cmd_busy <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/enc_txn_seq_chk.sv
module enc_txn_seq_chk
  import enc_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd_id,
  input logic       cmd_start,
  input logic       cmd_busy,
  input logic       cmd_fail,
  input logic       line_txd,
  input logic       line_de
);

  // R4
  de_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_busy |-> !line_de);

  // R4
  de_covers_low_chk: assert property (@(posedge clk) disable iff (rst)
    !line_txd |-> line_de);

  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_busy) |-> $past(cmd_start));

  // R7
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_busy && id_ok(cmd_id)) |=> (cmd_busy && !cmd_fail));

  // R7
  fail_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_busy && !cmd_start) |=> $stable(cmd_fail));

  // R8
  bad_id_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_busy && !id_ok(cmd_id)) |=> (!cmd_busy && cmd_fail));

endmodule

bind enc_txn_seq enc_txn_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_id(cmd_id), .cmd_start(cmd_start),
  .cmd_busy(cmd_busy), .cmd_fail(cmd_fail), .line_txd(line_txd), .line_de(line_de)
);

// File: tb/test_enc_txn_seq.sv
`timescale 1ns/1ps
module test_enc_txn_seq;
  localparam int CLK_HZ  = 200_000_000;
  localparam int BAUD_HZ = 12_500_000;
  localparam int OSR     = 16;
  localparam int TO_BITS = 24;
  localparam int DEPTH   = 16;
  localparam int AW      = 4;
  localparam int BT      = 16;   // clocks per bit with these parameters

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    cmd_id;
  logic [7:0]    cmd_addr, cmd_wdata;
  logic          cmd_start;
  logic          cmd_busy, cmd_fail;
  logic [AW:0]   reply_cnt;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          line_txd, line_de, line_rxd;
  logic          enc_line = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int mon_bad = 0;

  always #2.5 clk = ~clk;

  // half-duplex bus: receiver always listens
  assign line_rxd = line_de ? line_txd : enc_line;

  enc_txn_seq #(
    .CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .OSR(OSR),
    .TIMEOUT_BITS(TO_BITS), .REPLY_DEPTH(DEPTH)
  ) i_enc_txn_seq (
    .clk(clk), .rst(rst), .cmd_id(cmd_id), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_start(cmd_start), .cmd_busy(cmd_busy),
    .cmd_fail(cmd_fail), .reply_cnt(reply_cnt), .rd_addr(rd_addr),
    .rd_data(rd_data), .line_txd(line_txd), .line_de(line_de), .line_rxd(line_rxd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle bus model: R4 line rules
  always @(negedge clk) begin
    if (!rst) begin
      if (!line_txd && !line_de) mon_bad++;
      if (!cmd_busy && line_de)  mon_bad++;
    end
  end

  function automatic bit supported(input logic [3:0] id);
    return id inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'hC, 4'hD};
  endfunction

  function automatic int exp_rsp(input logic [3:0] id);
    if (id == 4'h3) return 11;
    if (id == 4'h2 || id == 4'h6 || id == 4'hD) return 4;
    return 6;
  endfunction

  function automatic int exp_req_n(input logic [3:0] id);
    if (id == 4'h6) return 4;
    if (id == 4'hD) return 3;
    return 1;
  endfunction

  function automatic logic [7:0] exp_req(input logic [3:0] id, input logic [7:0] a,
                                         input logic [7:0] w, input int k);
    logic [7:0] c;
    c = {id[0] ^ id[1] ^ id[2] ^ id[3], id, 3'b010};
    if (k == 0) return c;
    if (k == 1) return a;
    if (id == 4'h6) return (k == 2) ? w : (c ^ a ^ w);
    return c ^ a;
  endfunction

  function automatic logic [7:0] enc_val(input logic [3:0] id, input int k);
    return 8'h3C ^ 8'(k * 37) ^ {id, id};
  endfunction

  task automatic get_byte(output logic [7:0] b, output bit ok);
    int i;
    b  = '0;
    ok = 1'b0;
    for (i = 0; i < 3000 && line_txd; i++) @(negedge clk);
    if (line_txd) return;
    repeat (BT / 2) @(negedge clk);
    ok = !line_txd && line_de;
    for (int j = 0; j < 8; j++) begin
      repeat (BT) @(negedge clk);
      b[j] = line_txd;
    end
    repeat (BT) @(negedge clk);
    ok = ok && line_txd;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit good_stop);
    enc_line = 1'b0;
    repeat (BT) @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      enc_line = b[j];
      repeat (BT) @(negedge clk);
    end
    enc_line = good_stop;
    repeat (BT) @(negedge clk);
    enc_line = 1'b1;
  endtask

  // one transaction; n_send reply bytes, bad_at marks a byte with a bad stop
  task automatic run_txn(input string req, input logic [3:0] id, input logic [7:0] a,
                         input logic [7:0] w, input int n_send, input int bad_at,
                         input bit restart, input bit exp_fail, input int exp_cnt);
    logic [7:0] b;
    bit ok;
    int i;
    @(negedge clk);
    cmd_id = id; cmd_addr = a; cmd_wdata = w; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(cmd_busy == 1'b1 && cmd_fail == 1'b0, "R7", "busy after start", cmd_busy, 1);
    for (int k = 0; k < exp_req_n(id); k++) begin
      get_byte(b, ok);
      chk(ok, "R2", "request character framing", ok, 1);
      chk(b == exp_req(id, a, w, k), "R3", "request byte", b, exp_req(id, a, w, k));
      if (k == 0 && restart) begin
        cmd_id = 4'h3; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
      end
    end
    for (i = 0; i < 3000 && line_de; i++) @(negedge clk);
    chk(!line_de, "R4", "driver released", line_de, 0);
    repeat (40) @(negedge clk);
    for (int k = 0; k < n_send; k++) begin
      put_byte(enc_val(id, k), k != bad_at);
      if (k == bad_at) break;
      repeat (20) @(negedge clk);
    end
    for (i = 0; i < 3000 && cmd_busy; i++) @(negedge clk);
    chk(!cmd_busy, req, "busy cleared", cmd_busy, 0);
    chk(cmd_fail == exp_fail, req, "fail flag", cmd_fail, exp_fail);
    chk(reply_cnt == exp_cnt, req, "reply count (R5 echo excluded)", reply_cnt, exp_cnt);
    for (int k = 0; k < exp_cnt; k++) begin
      rd_addr = AW'(k);
      @(negedge clk);
      chk(rd_data == enc_val(id, k), "R6", "reply byte", rd_data, enc_val(id, k));
    end
    repeat (60) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    int m0;
    rst = 1'b1; cmd_id = '0; cmd_addr = '0; cmd_wdata = '0; cmd_start = 1'b0; rd_addr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!cmd_busy && !cmd_fail && !line_de && line_txd && reply_cnt == 0,
        "R1", "reset state", {cmd_busy, cmd_fail, line_de, line_txd}, 4'b0001);

    run_txn("R6", 4'h0, 8'h00, 8'h00, 6, -1, 1'b0, 1'b0, 6);
    run_txn("R6", 4'h3, 8'h00, 8'h00, 11, -1, 1'b0, 1'b0, 11);
    run_txn("R6", 4'h2, 8'h00, 8'h00, 4, -1, 1'b0, 1'b0, 4);
    run_txn("R6", 4'hC, 8'h00, 8'h00, 6, -1, 1'b0, 1'b0, 6);
    run_txn("R5", 4'h6, 8'h5A, 8'hC3, 4, -1, 1'b0, 1'b0, 4);
    run_txn("R5", 4'hD, 8'h21, 8'h00, 4, -1, 1'b0, 1'b0, 4);
    // R10: encoder stops after three of six bytes
    run_txn("R10", 4'h1, 8'h00, 8'h00, 3, -1, 1'b0, 1'b1, 3);

    // R8: unsupported ID
    @(negedge clk);
    cmd_id = 4'h5; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(!cmd_busy && cmd_fail && reply_cnt == 0, "R8", "unsupported ID rejected",
        {cmd_busy, cmd_fail}, 2'b01);
    m0 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!line_txd || line_de) m0++;
    end
    chk(m0 == 0, "R8", "line quiet after rejected ID", m0, 0);

    // R9: second start during ID 8 ignored
    run_txn("R9", 4'h8, 8'h00, 8'h00, 6, -1, 1'b1, 1'b0, 6);
    // R11: second reply byte has a bad stop bit
    run_txn("R11", 4'h7, 8'h00, 8'h00, 6, 1, 1'b0, 1'b1, 1);
    repeat (400) @(negedge clk);
    run_txn("R6", 4'h0, 8'h00, 8'h00, 6, -1, 1'b0, 1'b0, 6);

    chk(mon_bad == 0, "R4", "per-cycle driver enable rule", mon_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule